// File: doc/BRIEF.md
# Four-Slot Input Timestamp Capture

This block timestamps the edges of one external input. A free-running 32-bit counter advances on each clock edge while its run bit is set. When the input shows the edge that the current slot is waiting for, the counter value is copied into that slot's capture register. The sequencer then moves to the next of four slots in a fixed rotation. A timing engine can use it to measure pulse widths, periods or duty cycles from the stored stamps without servicing every edge in software.

Software reaches the block through a word-addressed register port with combinational read data and writes that take effect at the next clock edge. Each capture event and the counter wrap set a status flag. The flags can be cleared one by one by writing ones. A single interrupt line is raised while any enabled flag is pending and is held until software clears both the event flag and the global interrupt flag.

Top module: `stamp_cap`

## Requirements
- R1: After reset every register reads zero, except the identification word at byte offset 0x5C, which reads the ID_WORD parameter. The irq output is low after reset.
- R2: While control bit 20 is 1, the counter at offset 0x00 increases by one on every clock edge. A software write to 0x00 loads the written value.
- R3: While control bit 20 is 0, the counter keeps its value.
- R4: When a running counter passes from all-ones to zero, the overflow event (event 4) sets flag bit 21 of the register at 0x2C.
- R5: With bit 8 of control (0x28) set, each qualifying input edge stores the counter value into the current slot. Slots 0 to 3 sit at 0x08, 0x0C, 0x10 and 0x14 and are filled in that order. The distance between two stored stamps equals the spacing, in clock cycles, of the two input edges.
- R6: While control bit 8 is 0, input edges change no capture register.
- R7: Control bit 2*i sets the edge for slot i: 0 means rising, 1 means falling. An edge of the other kind is not captured in that slot.
- R8: Control bits 18:17 hold the last slot S. After slot S is loaded, the next capture goes to slot 0. Any write to control returns the sequencer to slot 0.
- R9: With control bit 16 set (single pass), edges after slot S is loaded are ignored until control is written again.
- R10: A capture into slot i sets flag bit 17+i of 0x2C. Writing 1 to bit i+1 of 0x30 clears flag i, and a 0 bit leaves it unchanged. If an event and its clear land in the same cycle, the event wins.
- R11: Bits 5:1 of 0x2C enable events 0 to 4. irq rises in the cycle after an enabled flag is set. It stays high until one write to 0x30 clears bit 0 and every enabled pending flag. A flag whose enable is 0 does not raise irq.
- R12: Software can write the capture registers and read the written value back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is one where the stored stamp has to be predicted exactly, because two synchronizer stages and an edge detector lie between the pin and the capture. The stimulus gets there in two ways. First, it stops the counter and preloads it, so every capture must equal the preloaded value whatever the latency. Second, with the counter running, it checks only the difference between two stamps against the known spacing of the input edges. Single-pass halting and the wrap after a short slot limit are reached by rewriting control, which also rewinds the sequencer to a known slot.

// File: rtl/stamp_cap_pkg.sv
package stamp_cap_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFS_CNT  = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_CAP  = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 7'h28;
    localparam logic [ADDR_W-1:0] OFS_INT  = 7'h2C;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 7'h30;
    localparam logic [ADDR_W-1:0] OFS_ID   = 7'h5C;

    localparam int BIT_LOAD     = 8;
    localparam int BIT_ONESHOT  = 16;
    localparam int BIT_STOP_LSB = 17;
    localparam int BIT_RUN      = 20;
    localparam int EN_LSB       = 1;
    localparam int FLG_LSB      = 17;

    typedef struct packed {
        logic [1:0] idx;
        logic       armed;
    } seq_st_t;
endpackage

// File: rtl/stamp_cap_edge.sv
module stamp_cap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = sig_in;
        for (int k = 1; k <= LAST; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise =  chain_q[LAST-1] & ~chain_q[LAST];
    assign fall = ~chain_q[LAST-1] &  chain_q[LAST];
endmodule

// File: rtl/stamp_cap_seq.sv
module stamp_cap_seq
    import stamp_cap_pkg::*;
#(
    parameter int N_SLOTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               fall,
    input  logic [N_SLOTS-1:0] pol,
    input  logic               load_en,
    input  logic               oneshot,
    input  logic [1:0]         last_slot,
    input  logic               rearm,
    output logic [N_SLOTS-1:0] cap_upd
);
    seq_st_t d, q;
    logic    hit;

    always_comb begin
        d   = q;
        hit = load_en && q.armed && (pol[q.idx] ? fall : rise);
        if (rearm) begin
            d.idx   = '0;
            d.armed = 1'b1;
        end else if (hit) begin
            if (q.idx == last_slot || int'(q.idx) == N_SLOTS - 1) begin
                d.idx   = '0;
                d.armed = !oneshot;
            end else begin
                d.idx = q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.idx   <= '0;
            q.armed <= 1'b1;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_upd
        assign cap_upd[g] = hit && (int'(q.idx) == g);
    end
endmodule

// File: rtl/stamp_cap.sv
module stamp_cap
    import stamp_cap_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter int          N_SLOTS = 4,
    parameter int          SYNC_N  = 2,
    parameter logic [31:0] ID_WORD = 32'h5C0A_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [6:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        cap_in,
    output logic        irq
);
    localparam int NEV = N_SLOTS + 1;

    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [N_SLOTS-1:0][CNT_W-1:0] cap;
        logic [31:0]                   ctrl;
        logic [NEV-1:0]                en;
        logic [NEV-1:0]                flg;
        logic                          gflag;
    } st_t;

    st_t d, q;

    logic               rise, fall;
    logic [N_SLOTS-1:0] cap_upd;
    logic [N_SLOTS-1:0] pol;
    logic               wr, cnt_wr, ctrl_wr, clr_wr, ovf;
    logic [NEV-1:0]     clr_mask;

    assign wr      = bus_sel && bus_we;
    assign cnt_wr  = wr && bus_addr == OFS_CNT;
    assign ctrl_wr = wr && bus_addr == OFS_CTRL;
    assign clr_wr  = wr && bus_addr == OFS_CLR;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_pol
        assign pol[g] = q.ctrl[2*g];
    end

    stamp_cap_edge #(.STAGES(SYNC_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (cap_in),
        .rise   (rise),
        .fall   (fall)
    );

    stamp_cap_seq #(.N_SLOTS(N_SLOTS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .pol       (pol),
        .load_en   (q.ctrl[BIT_LOAD]),
        .oneshot   (q.ctrl[BIT_ONESHOT]),
        .last_slot (q.ctrl[BIT_STOP_LSB +: 2]),
        .rearm     (ctrl_wr),
        .cap_upd   (cap_upd)
    );

    always_comb begin
        d        = q;
        ovf      = 1'b0;
        clr_mask = clr_wr ? bus_wdata[1 +: NEV] : '0;
        if (cnt_wr) begin
            d.cnt = bus_wdata[CNT_W-1:0];
        end else if (q.ctrl[BIT_RUN]) begin
            d.cnt = q.cnt + 1'b1;
            ovf   = (q.cnt == '1);
        end
        for (int i = 0; i < N_SLOTS; i++) begin
            if (wr && bus_addr == 7'(int'(OFS_CAP) + 4*i)) d.cap[i] = bus_wdata[CNT_W-1:0];
            if (cap_upd[i]) d.cap[i] = q.cnt;
        end
        if (ctrl_wr) d.ctrl = bus_wdata;
        if (wr && bus_addr == OFS_INT) d.en = bus_wdata[EN_LSB +: NEV];
        d.flg   = (q.flg & ~clr_mask) | {ovf, cap_upd};
        d.gflag = (q.gflag & ~(clr_wr && bus_wdata[0])) | (|(d.flg & d.en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT:  bus_rdata = 32'(q.cnt);
            OFS_CTRL: bus_rdata = q.ctrl;
            OFS_INT: begin
                bus_rdata[0]             = q.gflag;
                bus_rdata[EN_LSB +: NEV]  = q.en;
                bus_rdata[FLG_LSB +: NEV] = q.flg;
            end
            OFS_ID:   bus_rdata = ID_WORD;
            default: begin
                for (int i = 0; i < N_SLOTS; i++) begin
                    if (bus_addr == 7'(int'(OFS_CAP) + 4*i)) bus_rdata = 32'(q.cap[i]);
                end
            end
        endcase
    end

    assign irq = q.gflag;
endmodule

// File: rtl/stamp_cap_chk.sv
module stamp_cap_chk #(
    parameter int CNT_W   = 32,
    parameter int N_SLOTS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cnt,
    input logic               run,
    input logic               load_en,
    input logic               cnt_wr,
    input logic               clr_wr,
    input logic [N_SLOTS-1:0] cap_upd,
    input logic               irq
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !cnt_wr |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_wr |=> $stable(cnt));

    // R5
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_upd));

    // R6
    load_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |-> cap_upd == '0);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_wr |=> irq);
endmodule

bind stamp_cap stamp_cap_chk #(.CNT_W(CNT_W), .N_SLOTS(N_SLOTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (q.cnt),
    .run     (q.ctrl[20]),
    .load_en (q.ctrl[8]),
    .cnt_wr  (cnt_wr),
    .clr_wr  (clr_wr),
    .cap_upd (cap_upd),
    .irq     (irq)
);

// File: tb/stamp_cap_tb.sv
module stamp_cap_tb;
    localparam logic [31:0] ID = 32'h5C0A_0001;
    localparam logic [31:0] RUN = 32'h0010_0000, LOAD = 32'h0000_0100;
    localparam logic [31:0] ONE = 32'h0001_0000, S1 = 32'h0002_0000, S3 = 32'h0006_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, cap_in = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          checks = 0, fails = 0;

    always #5 clk = ~clk;

    stamp_cap #(.ID_WORD(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic drive(input logic v);
        cap_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle();
        drive(1'b0);
        wr(7'h28, 32'h0);
        wr(7'h30, 32'h3F);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8'h60; a += 4) begin
            rd(7'(a), v);
            chk("R1 reg", v, (a == 8'h5C) ? ID : 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v, h;
        wr(7'h28, RUN);
        wr(7'h00, 32'd100);
        repeat (10) @(negedge clk);
        rd(7'h00, v);
        chk("R2 count", v, 32'd110);
        wr(7'h28, 32'h0);
        rd(7'h00, h);
        repeat (5) @(negedge clk);
        rd(7'h00, v);
        chk("R3 hold", v, h);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        settle();
        wr(7'h28, RUN);
        wr(7'h00, 32'hFFFF_FFFE);
        @(negedge clk);
        rd(7'h2C, v);
        chk("R4 no flag yet", v[21], 1'b0);
        @(negedge clk);
        rd(7'h2C, v);
        chk("R4 flag", 32'(v[21]), 32'h1);
        wr(7'h28, 32'h0);
        rd(7'h00, v);
        chk("R4 wrapped", v, 32'h1);
        wr(7'h30, 32'h0);
        rd(7'h2C, v);
        chk("R10 zero write", 32'(v[21]), 32'h1);
        wr(7'h30, 32'h20);
        rd(7'h2C, v);
        chk("R10 clear", 32'(v[21]), 32'h0);
    endtask

    task automatic t_rotate();
        logic [31:0] v;
        settle();
        wr(7'h28, LOAD | S3);
        for (int i = 0; i < 5; i++) begin
            wr(7'h00, 32'd1000 + 32'(i));
            drive(1'b1);
            drive(1'b0);
        end
        rd(7'h08, v); chk("R5 slot0 again", v, 32'd1004);
        rd(7'h0C, v); chk("R5 slot1", v, 32'd1001);
        rd(7'h10, v); chk("R5 slot2", v, 32'd1002);
        rd(7'h14, v); chk("R5 slot3", v, 32'd1003);
        rd(7'h2C, v); chk("R10 capture flags", 32'(v[20:17]), 32'hF);
    endtask

    task automatic t_spacing();
        logic [31:0] a, b;
        settle();
        wr(7'h28, RUN | LOAD | S3);
        cap_in = 1'b1;
        repeat (5) @(negedge clk);
        cap_in = 1'b0;
        repeat (15) @(negedge clk);
        cap_in = 1'b1;
        repeat (5) @(negedge clk);
        wr(7'h28, 32'h0);
        rd(7'h08, a);
        rd(7'h0C, b);
        chk("R5 spacing", b - a, 32'd20);
    endtask

    task automatic t_loadoff();
        logic [31:0] v;
        settle();
        wr(7'h28, S3);
        wr(7'h08, 32'hAAAA);
        wr(7'h0C, 32'hBBBB);
        rd(7'h08, v); chk("R12 write back", v, 32'hAAAA);
        wr(7'h00, 32'd77);
        drive(1'b1); drive(1'b0); drive(1'b1);
        rd(7'h08, v); chk("R6 slot0 kept", v, 32'hAAAA);
        rd(7'h0C, v); chk("R6 slot1 kept", v, 32'hBBBB);
        drive(1'b0);
        wr(7'h28, LOAD | S3);
        drive(1'b1);
        rd(7'h08, v); chk("R6 load on", v, 32'd77);
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        settle();
        wr(7'h08, 32'h0);
        wr(7'h0C, 32'h0);
        wr(7'h28, LOAD | S3 | 32'h1);
        wr(7'h00, 32'd500);
        drive(1'b1);
        rd(7'h08, v); chk("R7 rise ignored", v, 32'h0);
        drive(1'b0);
        rd(7'h08, v); chk("R7 fall taken", v, 32'd500);
        wr(7'h00, 32'd600);
        drive(1'b1);
        rd(7'h0C, v); chk("R7 slot1 rise", v, 32'd600);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        settle();
        wr(7'h10, 32'h1234);
        wr(7'h28, LOAD | S1);
        for (int i = 0; i < 3; i++) begin
            wr(7'h00, 32'd10 + 32'(i));
            drive(1'b1);
            drive(1'b0);
        end
        rd(7'h08, v); chk("R8 wrap to slot0", v, 32'd12);
        rd(7'h0C, v); chk("R8 slot1", v, 32'd11);
        rd(7'h10, v); chk("R8 slot2 untouched", v, 32'h1234);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        settle();
        wr(7'h28, ONE | LOAD | S1);
        for (int i = 0; i < 3; i++) begin
            wr(7'h00, 32'd20 + 32'(i));
            drive(1'b1);
            drive(1'b0);
        end
        rd(7'h08, v); chk("R9 halted slot0", v, 32'd20);
        rd(7'h0C, v); chk("R9 slot1", v, 32'd21);
        wr(7'h28, ONE | LOAD | S1);
        wr(7'h00, 32'd23);
        drive(1'b1);
        rd(7'h08, v); chk("R9 rearmed", v, 32'd23);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        settle();
        wr(7'h2C, 32'h2);
        chk("R11 idle", 32'(irq), 32'h0);
        wr(7'h28, LOAD | S3);
        wr(7'h00, 32'd5);
        drive(1'b1);
        chk("R11 raised", 32'(irq), 32'h1);
        rd(7'h2C, v); chk("R10 flag0", 32'(v[17]), 32'h1);
        wr(7'h30, 32'h1);
        chk("R11 held", 32'(irq), 32'h1);
        wr(7'h30, 32'h3);
        chk("R11 cleared", 32'(irq), 32'h0);
        drive(1'b0);
        drive(1'b1);
        rd(7'h2C, v); chk("R10 flag1", 32'(v[18]), 32'h1);
        chk("R11 masked", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_overflow();
        t_rotate();
        t_spacing();
        t_loadoff();
        t_polarity();
        t_wrap();
        t_oneshot();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule